// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds a 16-bit power-management control word that software reaches through a byte-addressable register port. The word has two byte lanes, at offsets BASE_OFF and BASE_OFF+1. Bit 0 of the word is the interrupt-enable flag. The other bits are general control bits that are stored and read back. Bit 13 is a sleep trigger. It is never stored. When a write sets it, the write starts a sleep request whose kind comes from the 3-bit type field in bits 12:10.

The decoder turns a triggered write into single-cycle request pulses: power-off, suspend-to-RAM, or suspend-to-disk. A suspend-to-disk request is always paired with a power-off request. Two static configuration inputs change only while reset is held. One gives the type code that means suspend-to-disk. The other selects a fixed-interrupt mode: in that mode the interrupt-enable flag comes out of reset set, and the external enable/disable commands have no effect. The register port always accepts an access in the cycle it is presented, so it has no back-pressure. Reads are combinational.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset the stored word is 0x0000, except that bit 0 is 1 when cfg_fixed_sci is 1.
- R2: A 16-bit write (wr_wide=1) at offset 4 stores wr_data with bit 13 forced to 0, so bit 13 always reads back as 0.
- R3: A byte write (wr_wide=0) at offset 5 replaces bits 15:8 with wr_data[7:0] and keeps bits 7:0.
- R4: A byte write at offset 4 stores wr_data[7:0] zero-extended into the whole word.
- R5: A read at offset 4 returns the word and a read at offset 5 returns the word shifted right by 8. A read at any other offset returns 0. A write at any other offset, and a 16-bit write at offset 5, change nothing.
- R6: A write whose merged value has bit 13 set and bits 12:10 equal to 0 gives a one-cycle off_req pulse in the cycle after the write.
- R7: The same with type 1 gives a one-cycle ram_req pulse.
- R8: For a type from 2 to 7 that equals cfg_disk_type, disk_req and off_req pulse together. For any other such type, no pulse is produced.
- R9: A write with bit 13 clear produces no request pulse, whatever its type field holds.
- R10: With cfg_fixed_sci=0, sci_on sets bit 0 and sci_off clears it. sci_on wins if both are asserted. A command overrides bit 0 of a write in the same cycle.
- R11: With cfg_fixed_sci=1, sci_on and sci_off leave the word unchanged. Writes still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disk_type | input | 3 | Type code meaning suspend-to-disk (static) |
| cfg_fixed_sci | input | 1 | Fixed-interrupt mode (static) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_wide | input | 1 | 1: 16-bit access, 0: byte access |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 16 | Read data |
| sci_on | input | 1 | Command to set the interrupt-enable bit |
| sci_off | input | 1 | Command to clear the interrupt-enable bit |
| off_req | output | 1 | Power-off request pulse |
| ram_req | output | 1 | Suspend-to-RAM request pulse |
| disk_req | output | 1 | Suspend-to-disk request pulse |

## Verification
The assertions check the following on every cycle:
- stored bit 13 stays clear;
- power-off and suspend-to-RAM never assert together;
- a disk pulse always comes with a power-off pulse;
- every request pulse follows a write;
- in fixed mode, the enable bit ignores commands.

The bench scenarios show what the assertions cannot:
- the byte-lane merging at offsets 4 and 5;
- the mapping from each type code to a request, including the case where a code does not match the configured disk type;
- the reset value in each mode;
- the precedence between commands and writes.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;
  localparam int CTL_W      = 16;
  localparam int SCI_BIT    = 0;
  localparam int TRIG_BIT   = 13;
  localparam int TYPE_LO    = 10;
  localparam int TYPE_W     = 3;
  localparam int LANE_W     = CTL_W / 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_OFF  = 2'd1,
    ACT_RAM  = 2'd2,
    ACT_DISK = 2'd3
  } sleep_act_e;
endpackage

// File: rtl/pm_ctl_wport.sv
module pm_ctl_wport
  import pm_sleep_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic [CTL_W-1:0]  cur_q,
  output logic              wr_hit,
  output logic [CTL_W-1:0]  merged
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_OFF + 1);

  logic lo_hit, hi_hit;

  assign lo_hit = wr_en && (wr_addr == LO_A);
  assign hi_hit = wr_en && (wr_addr == HI_A) && !wr_wide;
  assign wr_hit = lo_hit || hi_hit;

  always_comb begin
    merged = cur_q;
    if (lo_hit && wr_wide)
      merged = wr_data;
    else if (lo_hit)
      merged = {{LANE_W{1'b0}}, wr_data[LANE_W-1:0]};
    else if (hi_hit)
      merged = {wr_data[LANE_W-1:0], cur_q[LANE_W-1:0]};
  end
endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              trig,
  input  logic [TYPE_W-1:0] typ,
  input  logic [TYPE_W-1:0] cfg_disk_type,
  output logic              off_req,
  output logic              ram_req,
  output logic              disk_req
);
  sleep_act_e act;

  always_comb begin
    act = ACT_NONE;
    if (wr_hit && trig) begin
      if (typ == TYPE_W'(0))
        act = ACT_OFF;
      else if (typ == TYPE_W'(1))
        act = ACT_RAM;
      else if (typ == cfg_disk_type)
        act = ACT_DISK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_req  <= 1'b0;
      ram_req  <= 1'b0;
      disk_req <= 1'b0;
    end else begin
      off_req  <= (act == ACT_OFF) || (act == ACT_DISK);
      ram_req  <= (act == ACT_RAM);
      disk_req <= (act == ACT_DISK);
    end
  end

  // R8
  disk_pairs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_req |-> off_req);
  // R7
  ram_excl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_req && off_req));
  // R6
  pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req || ram_req) |-> $past(wr_hit && trig));
endmodule

// File: rtl/pm_ctl_store.sv
module pm_ctl_store
  import pm_sleep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fixed_sci,
  input  logic             wr_hit,
  input  logic [CTL_W-1:0] merged,
  input  logic             sci_on,
  input  logic             sci_off,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] TRIG_MASK = CTL_W'(1) << TRIG_BIT;

  logic [CTL_W-1:0] nxt;

  always_comb begin
    nxt = wr_hit ? (merged & ~TRIG_MASK) : ctl_q;
    if (!cfg_fixed_sci) begin
      if (sci_on)
        nxt[SCI_BIT] = 1'b1;
      else if (sci_off)
        nxt[SCI_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q          <= '0;
      ctl_q[SCI_BIT] <= cfg_fixed_sci;
    end else begin
      ctl_q <= nxt;
    end
  end

  // R2
  trig_never_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[TRIG_BIT]);
  // R11
  fixed_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fixed_sci && !wr_hit) |=> $stable(ctl_q));
  // R10
  sci_on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fixed_sci && sci_on) |=> ctl_q[SCI_BIT]);
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_sleep_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_disk_type,
  input  logic              cfg_fixed_sci,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  input  logic              sci_on,
  input  logic              sci_off,
  output logic              off_req,
  output logic              ram_req,
  output logic              disk_req
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_OFF + 1);

  logic [CTL_W-1:0] ctl_q, merged;
  logic             wr_hit;

  pm_ctl_wport #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_wport (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .cur_q(ctl_q), .wr_hit(wr_hit), .merged(merged)
  );

  pm_ctl_store u_store (
    .clk(clk), .rst_n(rst_n), .cfg_fixed_sci(cfg_fixed_sci),
    .wr_hit(wr_hit), .merged(merged), .sci_on(sci_on), .sci_off(sci_off),
    .ctl_q(ctl_q)
  );

  pm_sleep_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .trig(merged[TRIG_BIT]),
    .typ(merged[TYPE_LO +: TYPE_W]), .cfg_disk_type(cfg_disk_type),
    .off_req(off_req), .ram_req(ram_req), .disk_req(disk_req)
  );

  always_comb begin
    if (rd_addr == LO_A)
      rd_data = ctl_q;
    else if (rd_addr == HI_A)
      rd_data = {{LANE_W{1'b0}}, ctl_q[CTL_W-1:LANE_W]};
    else
      rd_data = '0;
  end

  // R5
  hi_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == HI_A) |-> (rd_data[CTL_W-1:LANE_W] == '0));
endmodule

// File: tb/pm_sleep_ctrl_test.sv
`timescale 1ns/1ps
module pm_sleep_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_disk_type = 3'd4;
  logic        cfg_fixed_sci = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, sci_on = 1'b0, sci_off = 1'b0;
  logic [3:0]  wr_addr = 4'd0, rd_addr = 4'd4;
  logic [15:0] wr_data = 16'h0, rd_data;
  logic        off_req, ram_req, disk_req;

  int checks = 0, fails = 0;
  int mval = 0;

  always #2.5 clk = ~clk;

  pm_sleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_disk_type(cfg_disk_type),
    .cfg_fixed_sci(cfg_fixed_sci), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_wide(wr_wide), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sci_on(sci_on), .sci_off(sci_off), .off_req(off_req), .ram_req(ram_req),
    .disk_req(disk_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit fixed, input int dcode);
    rst_n = 1'b0; cfg_fixed_sci = fixed; cfg_disk_type = 3'(dcode);
    wr_en = 0; sci_on = 0; sci_off = 0; rd_addr = 4'd4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mval = fixed ? 1 : 0;
    chk("R1 reset value", rd_data, mval);
  endtask

  // one clock of stimulus, model update, then compare everything
  task automatic step(input bit we, input int addr, input bit wide, input int data,
                      input bit on, input bit off, input string tag);
    int v;
    int t;
    bit e_off, e_ram, e_disk;
    v = mval; e_off = 0; e_ram = 0; e_disk = 0;
    wr_en = we; wr_addr = 4'(addr); wr_wide = wide; wr_data = 16'(data);
    sci_on = on; sci_off = off;
    if (we && addr == 4 && wide) v = data & 16'hFFFF;
    else if (we && addr == 4) v = data & 8'hFF;
    else if (we && addr == 5 && !wide) v = ((data & 8'hFF) << 8) | (mval & 8'hFF);
    if (v != mval || (we && (addr == 4 || (addr == 5 && !wide)))) begin
      if ((v >> 13) & 1) begin
        t = (v >> 10) & 7;
        if (t == 0) e_off = 1;
        else if (t == 1) e_ram = 1;
        else if (t == int'(cfg_disk_type)) begin e_off = 1; e_disk = 1; end
      end
      v = v & ~(1 << 13);
    end
    if (!cfg_fixed_sci) begin
      if (on) v = v | 1;
      else if (off) v = v & ~1;
    end
    mval = v;
    @(posedge clk);
    #1;
    wr_en = 0; sci_on = 0; sci_off = 0;
    chk({tag, " word"}, rd_data, mval);
    chk({tag, " off_req"}, off_req, e_off);
    chk({tag, " ram_req"}, ram_req, e_ram);
    chk({tag, " disk_req"}, disk_req, e_disk);
  endtask

  task automatic rd_at(input int addr, input int exp, input string tag);
    rd_addr = 4'(addr);
    #1 chk(tag, rd_data, exp);
    rd_addr = 4'd4;
  endtask

  initial begin
    #(100000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0, 4);
    step(1, 4, 1, 16'h1234, 0, 0, "R2 plain write");
    step(1, 4, 1, 16'hFFFF, 0, 0, "R2 R8 trigger type7 mismatch");
    chk("R2 bit13 reads 0", (rd_data >> 13) & 1, 0);
    rd_at(5, 16'h00DF, "R5 high read");
    rd_at(7, 0, "R5 other offset read");
    step(1, 5, 0, 16'h000A, 0, 0, "R3 high byte write");
    step(1, 4, 0, 16'hAB5C, 0, 0, "R4 low byte write");
    step(1, 6, 1, 16'h7777, 0, 0, "R5 other offset write ignored");
    step(1, 5, 1, 16'h7777, 0, 0, "R5 wide write at high ignored");
    step(1, 4, 1, 16'h2000, 0, 0, "R6 type0 power off");
    step(0, 0, 0, 0, 0, 0, "R6 pulse single cycle");
    step(1, 4, 1, 16'h2400, 0, 0, "R7 type1 suspend ram");
    step(1, 4, 1, 16'h3000, 0, 0, "R8 type4 disk match");
    step(1, 4, 1, 16'h3400, 0, 0, "R8 type5 no match");
    step(1, 5, 0, 16'h0020, 0, 0, "R6 trigger via high byte");
    step(1, 5, 0, 16'h0030, 0, 0, "R8 disk via high byte");
    step(1, 4, 1, 16'h1C05, 0, 0, "R9 type set no trigger");
    step(0, 0, 0, 0, 1, 0, "R10 sci_on");
    step(0, 0, 0, 0, 0, 1, "R10 sci_off");
    step(0, 0, 0, 0, 1, 1, "R10 both on wins");
    step(1, 4, 1, 16'h0100, 1, 0, "R10 on beats write");
    step(1, 4, 1, 16'h0101, 0, 1, "R10 off beats write");

    do_reset(1'b1, 2);
    step(0, 0, 0, 0, 0, 1, "R11 sci_off ignored");
    step(1, 4, 1, 16'h0000, 0, 0, "R11 write still applies");
    step(0, 0, 0, 0, 1, 0, "R11 sci_on ignored");
    step(1, 4, 1, 16'h2800, 0, 0, "R8 type2 disk match");
    step(1, 4, 1, 16'h3000, 0, 0, "R8 type4 no match");
    step(1, 4, 1, 16'h2401, 0, 1, "R7 R11 ram with ignored off");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule